// File: doc/BRIEF.md
# Hardware Debug Trap Unit

This block watches the linear addresses the execution core touches and raises a debug trap when one of four programmed breakpoints is hit. Each breakpoint slot has a 32-bit linear address, an enable, a length (1, 2 or 4 bytes) and an access-type qualifier. The length aligns the watched window downward. A hit occurs when any byte of the reported access falls inside that window. The block also follows the single-step trace flag across retired instructions and raises the same trap one instruction later than the flag was first seen set.

Every trap request carries the fixed vector 1. A sticky status register records which conditions caused it. Software programs and inspects the block through a small register port: slot addresses at indices 0 to 3, control at 4 and status at 5. The core reports each access with a valid strobe, the address, a size and a kind. It reports each retired instruction with a strobe and the trace-flag value, which is bit 8 of the flags word, sampled at that retirement.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset every slot address, the control word, the status word and `trap_req` are zero, so no breakpoint is enabled.
- R2: Register indices 0 to 3 read back the written slot addresses in full. Index 4 keeps only control bits 3:0 and 31:16, and the other bits read as zero. Index 5 holds the status, and indices 6 and 7 read zero.
- R3: The control fields are positioned as follows. Slot i is enabled by bit i. Its type is at bits 16+4i and 17+4i, and its length is at bits 18+4i and 19+4i. Length 00 or 10 watches 1 byte, 01 watches 2 bytes aligned to an even address, and 11 watches 4 bytes aligned to a multiple of four. A hit needs any byte of the access (size code 0 = 1, 1 = 2, 2 = 4 bytes) to overlap the window.
- R4: Type 00 matches only instruction fetches (kind 0) and always watches exactly 1 byte. Type 01 matches only writes (kind 2). Type 11 matches reads (kind 1) and writes. Type 10 never matches.
- R5: A slot whose enable bit is clear never sets its status bit.
- R6: All four slots are compared against each access in parallel. Every slot that hits sets its status bit (bit i) in the same cycle.
- R7: `trap_req` is a one-cycle pulse in the cycle after a qualifying access or retirement, and `trap_vector` is always 1.
- R8: A retirement raises a step trap and sets status bit 4 only if the trace flag was set at the previous retirement. A flag first seen at instruction N traps after instruction N+1 and not after N.
- R9: Status bits are sticky. A status write ANDs the written value into them, so only writing a 0 clears a bit. A hardware set in the same cycle wins over the clear.
- R10: While `acc_valid` is low, no address comparison can cause a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access report valid |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code (0=1B, 1=2B, 2=4B) |
| acc_kind | input | 2 | Access kind (0 fetch, 1 read, 2 write) |
| ret_valid | input | 1 | Instruction retire strobe |
| ret_tf | input | 1 | Trace flag (flags bit 8) at this retirement |
| trap_req | output | 1 | Debug trap request pulse |
| trap_vector | output | 8 | Exception vector, always 1 |

## Verification
The hardest case to reach from the ports is an access that straddles a window edge, where the access starts below the aligned region and only its last byte falls inside. The stimulus table therefore places 2- and 4-byte accesses one byte before and one byte across each window boundary. An execution slot with a 4-byte length field is also probed at offset 1, to show that the length field is ignored for fetches. A directed case fires a hit in the same cycle that software writes zero to the status register, to show that the hardware set wins.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
    localparam int NUM_SLOTS  = 4;
    localparam int ADDR_W     = 32;
    localparam int STAT_W     = NUM_SLOTS + 1;
    localparam int FLD_BASE   = 16;
    localparam int FLD_STRIDE = 4;
    localparam logic [7:0] TRAP_VEC = 8'd1;

    localparam logic [2:0] IDX_CTRL = 3'd4;
    localparam logic [2:0] IDX_STAT = 3'd5;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC  = 2'b00,
        BT_WRITE = 2'b01,
        BT_RSVD  = 2'b10,
        BT_RDWR  = 2'b11
    } bp_type_e;
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
    import dbg_trap_pkg::*;
(
    input  logic              en_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        type_i,
    input  logic [1:0]        len_i,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_size_i,
    input  logic [1:0]        acc_kind_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W:0]   win_lo, win_hi, a_lo, a_hi;
    logic              kind_ok;

    always_comb begin
        // fetch breakpoints always watch exactly one byte
        mask = '0;
        if (type_i != BT_EXEC) begin
            case (len_i)
                2'b01:   mask = ADDR_W'(1);
                2'b11:   mask = ADDR_W'(3);
                default: mask = '0;
            endcase
        end
        win_lo = {1'b0, base_i & ~mask};
        win_hi = {1'b0, base_i | mask};
        a_lo   = {1'b0, acc_addr_i};
        case (acc_size_i)
            2'd1:    a_hi = a_lo + (ADDR_W+1)'(1);
            2'd2:    a_hi = a_lo + (ADDR_W+1)'(3);
            default: a_hi = a_lo;
        endcase
        case (type_i)
            BT_EXEC:  kind_ok = (acc_kind_i == KIND_FETCH);
            BT_WRITE: kind_ok = (acc_kind_i == KIND_WRITE);
            BT_RDWR:  kind_ok = (acc_kind_i == KIND_READ) || (acc_kind_i == KIND_WRITE);
            default:  kind_ok = 1'b0;
        endcase
        hit_o = en_i && acc_valid_i && kind_ok && (a_lo <= win_hi) && (a_hi >= win_lo);
    end

    always_comb begin
        AST_HIT_NEEDS_VALID: assert (!hit_o || acc_valid_i); // R10
    end
endmodule

// File: rtl/dbg_step_track.sv
module dbg_step_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ret_valid_i,
    input  logic ret_tf_i,
    output logic step_o
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ret_valid_i)
            st_d.armed = ret_tf_i;
        // trap only for an instruction that began with the flag already set
        step_o = ret_valid_i && st_q.armed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STEP_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> ret_valid_i); // R8
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
    import dbg_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [1:0]  acc_kind,
    input  logic        ret_valid,
    input  logic        ret_tf,
    output logic        trap_req,
    output logic [7:0]  trap_vector
);
    localparam logic [31:0] CTRL_MASK = {{(32-FLD_BASE){1'b1}}, {(FLD_BASE-NUM_SLOTS){1'b0}}, {NUM_SLOTS{1'b1}}};

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp;
        logic [31:0]                      ctrl;
        logic [STAT_W-1:0]                stat;
        logic                             trap;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SLOTS-1:0] hits;
    logic                 step_evt;
    logic                 wr_stat;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        dbg_bp_slot u_slot (
            .en_i        (st_q.ctrl[i]),
            .base_i      (st_q.bp[i]),
            .type_i      (st_q.ctrl[FLD_BASE + FLD_STRIDE*i +: 2]),
            .len_i       (st_q.ctrl[FLD_BASE + FLD_STRIDE*i + 2 +: 2]),
            .acc_valid_i (acc_valid),
            .acc_addr_i  (acc_addr),
            .acc_size_i  (acc_size),
            .acc_kind_i  (acc_kind),
            .hit_o       (hits[i])
        );
    end

    dbg_step_track u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid_i (ret_valid),
        .ret_tf_i    (ret_tf),
        .step_o      (step_evt)
    );

    always_comb begin
        st_d    = st_q;
        wr_stat = reg_we && (reg_addr == IDX_STAT);
        if (reg_we) begin
            if (reg_addr < 3'(NUM_SLOTS))
                st_d.bp[reg_addr[1:0]] = reg_wdata;
            else if (reg_addr == IDX_CTRL)
                st_d.ctrl = reg_wdata & CTRL_MASK;
        end
        if (wr_stat)
            st_d.stat = st_q.stat & reg_wdata[STAT_W-1:0];
        // hardware set takes priority over a software clear
        st_d.stat = st_d.stat | {step_evt, hits};
        st_d.trap = step_evt || (|hits);

        reg_rdata = '0;
        if (reg_addr < 3'(NUM_SLOTS))
            reg_rdata = st_q.bp[reg_addr[1:0]];
        else if (reg_addr == IDX_CTRL)
            reg_rdata = st_q.ctrl;
        else if (reg_addr == IDX_STAT)
            reg_rdata = 32'(st_q.stat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_req    = st_q.trap;
    assign trap_vector = TRAP_VEC;

    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(acc_valid || ret_valid)); // R7
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stat) |-> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat))); // R9
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stat[NUM_SLOTS-1:0] & ~$past(st_q.stat[NUM_SLOTS-1:0])) & ~$past(st_q.ctrl[NUM_SLOTS-1:0])) == '0); // R5
    AST_STEP_FROM_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat[NUM_SLOTS]) |-> $past(ret_valid)); // R8
    AST_NEW_BIT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stat & ~$past(st_q.stat)) != '0) |-> trap_req); // R6
endmodule

// File: tb/dbg_trap_unit_bench.sv
module dbg_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        ret_valid = 1'b0;
    logic        ret_tf = 1'b0;
    logic        trap_req;
    logic [7:0]  trap_vector;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dbg_trap_unit u_dbg_trap_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
        .ret_valid(ret_valid), .ret_tf(ret_tf), .trap_req(trap_req),
        .trap_vector(trap_vector)
    );

    // {addr, size, kind, expected hit bits}
    localparam logic [39:0] VEC [0:14] = '{
        {32'h0000_1000, 2'd0, 2'd1, 4'b0001},
        {32'h0000_0FFF, 2'd1, 2'd2, 4'b0001},
        {32'h0000_0FFE, 2'd1, 2'd1, 4'b0000},
        {32'h0000_1001, 2'd0, 2'd1, 4'b0000},
        {32'h0000_1000, 2'd0, 2'd0, 4'b0000},
        {32'h0000_2002, 2'd0, 2'd2, 4'b0010},
        {32'h0000_2000, 2'd2, 2'd1, 4'b0000},
        {32'h0000_1FFC, 2'd2, 2'd2, 4'b0000},
        {32'h0000_1FFE, 2'd2, 2'd2, 4'b0010},
        {32'h0000_3000, 2'd0, 2'd1, 4'b0100},
        {32'h0000_3002, 2'd1, 2'd2, 4'b0000},
        {32'h0000_4000, 2'd0, 2'd0, 4'b1000},
        {32'h0000_4001, 2'd0, 2'd0, 4'b0000},
        {32'h0000_4000, 2'd0, 2'd1, 4'b0000},
        {32'h0000_3FFF, 2'd1, 2'd0, 4'b1000}
    };

    function automatic logic [31:0] fld(int slot, logic [1:0] typ, logic [1:0] len);
        return (32'(typ) | (32'(len) << 2)) << (16 + 4*slot);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // one access cycle; on return the cycle after it is in progress
    task automatic access(logic [31:0] a, logic [1:0] s, logic [1:0] k, logic v);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_size = s; acc_kind = k;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic retire(logic tf);
        @(negedge clk);
        ret_valid = 1'b1; ret_tf = tf;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] ctrl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trap", 32'(trap_req), 0);
        rd(3'd4, r); check("R1 ctrl", r, 0);
        rd(3'd5, r); check("R1 status", r, 0);
        rd(3'd2, r); check("R1 slot2", r, 0);
        access(32'h0, 2'd0, 2'd0, 1'b1);
        check("R1 no trap before programming", 32'(trap_req), 0);

        // R2 register access
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, r); check("R2 ctrl mask", r, 32'hFFFF_000F);
        rd(3'd6, r); check("R2 idx6 zero", r, 0);
        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0000_2003);
        wr(3'd2, 32'h0000_3001);
        wr(3'd3, 32'h0000_4000);
        rd(3'd1, r); check("R2 slot1 readback", r, 32'h0000_2003);

        ctrl = 32'hF | fld(0, 2'b11, 2'b00) | fld(1, 2'b01, 2'b11)
                     | fld(2, 2'b11, 2'b01) | fld(3, 2'b00, 2'b11);
        wr(3'd4, ctrl);
        wr(3'd5, 32'h0);

        // R3 R4 R7 table walk
        foreach (VEC[i]) begin
            access(VEC[i][39:8], VEC[i][7:6], VEC[i][5:4], 1'b1);
            check($sformatf("R3 R4 R7 vec%0d trap", i), 32'(trap_req), 32'(VEC[i][3:0] != 0));
            rd(3'd5, r);
            check($sformatf("R3 R4 vec%0d status", i), r, 32'(VEC[i][3:0]));
            @(negedge clk);
            check($sformatf("R7 vec%0d pulse ends", i), 32'(trap_req), 0);
            wr(3'd5, 32'h0);
        end
        check("R7 vector", 32'(trap_vector), 1);

        // R4 reserved type never matches
        wr(3'd4, 32'h1 | fld(0, 2'b10, 2'b00));
        access(32'h0000_1000, 2'd0, 2'd2, 1'b1);
        check("R4 reserved type", 32'(trap_req), 0);

        // R3 length 10 watches one byte
        wr(3'd0, 32'h0000_1001);
        wr(3'd4, 32'h1 | fld(0, 2'b11, 2'b10));
        access(32'h0000_1000, 2'd0, 2'd1, 1'b1);
        check("R3 len10 below", 32'(trap_req), 0);
        access(32'h0000_1001, 2'd0, 2'd1, 1'b1);
        check("R3 len10 exact", 32'(trap_req), 1);
        wr(3'd5, 32'h0);

        // R5 disabled slot
        wr(3'd0, 32'h0000_1000);
        wr(3'd4, ctrl & ~32'h1);
        access(32'h0000_1000, 2'd0, 2'd1, 1'b1);
        rd(3'd5, r); check("R5 disabled status", r, 0);
        check("R5 disabled trap", 32'(trap_req), 0);

        // R10 valid low
        wr(3'd4, ctrl);
        access(32'h0000_1000, 2'd0, 2'd1, 1'b0);
        check("R10 invalid trap", 32'(trap_req), 0);
        rd(3'd5, r); check("R10 invalid status", r, 0);

        // R6 two slots hit together
        wr(3'd1, 32'h0000_1000);
        wr(3'd4, 32'h3 | fld(0, 2'b11, 2'b00) | fld(1, 2'b11, 2'b00));
        access(32'h0000_1000, 2'd0, 2'd2, 1'b1);
        rd(3'd5, r); check("R6 both bits", r, 32'h3);

        // R9 sticky, write-1 keeps, write-0 clears
        repeat (3) @(negedge clk);
        rd(3'd5, r); check("R9 sticky", r, 32'h3);
        wr(3'd5, 32'h1);
        rd(3'd5, r); check("R9 partial clear", r, 32'h1);
        wr(3'd5, 32'h0);
        rd(3'd5, r); check("R9 cleared", r, 0);
        // hit in the same cycle as the clear
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0;
        acc_valid = 1'b1; acc_addr = 32'h0000_1000; acc_size = 2'd0; acc_kind = 2'd1;
        @(negedge clk);
        reg_we = 1'b0; acc_valid = 1'b0;
        rd(3'd5, r); check("R9 set beats clear", r, 32'h3);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);

        // R8 single-step deferral
        retire(1'b1);
        check("R8 no trap on setting instr", 32'(trap_req), 0);
        repeat (2) @(negedge clk);
        retire(1'b0);
        check("R8 trap after next instr", 32'(trap_req), 1);
        rd(3'd5, r); check("R8 step bit", r, 32'h10);
        check("R7 step vector", 32'(trap_vector), 1);
        retire(1'b0);
        check("R8 no further trap", 32'(trap_req), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule